// File: doc/BRIEF.md
# Exception Entry Controller

This block decides, once per clock, whether the processor takes an exception and which one. Two kinds of request reach it. Four asynchronous requests arrive as levels: system reset, machine check, external interrupt and decrementer. A synchronous fault request comes from the pipeline. The block picks the winner by a fixed priority. It masks the external and decrementer requests with the external-enable bit of the machine state word. It then captures the saved context into two save/restore registers and produces the machine state value the handler runs under.

When an exception is taken, the block does four things in the same register stage. It records the resume address in the first save/restore register. It builds the second save/restore register: two fixed fields take exception-specific information and every other bit is copied from the current machine state word. It loads the new machine state value and presents the handler vector address together with a one-cycle redirect strobe. If a synchronous fault arrives while exceptions are disabled, the block does not vector. It enters a sticky error state that only a system reset exception clears.

Bit numbering of all 64-bit words in this description is big-endian: bit 0 is the most significant bit and bit 63 is the least significant bit.

Top module: `exc_entry_ctrl`

## Requirements
- R1: After a synchronous active-low reset, srr0, srr1, msr_new and vector are all zero, and redirect and err_state are low.
- R2: Simultaneous requests resolve as system reset > machine check > synchronous fault > external > decrementer. The vectors are 0x100 (reset), 0x200 (machine check), 0x700 (synchronous fault), 0x500 (external) and 0x900 (decrementer). Outputs change on the clock edge that samples the request.
- R3: On a taken synchronous fault srr0 receives cur_pc. On a taken asynchronous exception srr0 receives next_pc.
- R4: srr1 bits 33..36 take sync_info[9:6] and bits 42..47 take sync_info[5:0]. Bits 0..32, 37..41 and 48..63 are copied from msr_in.
- R5: On any taken exception msr_new is msr_in with bits 48 (external enable), 49, 58 and 59 cleared. A machine check also clears bit 51. A system reset gives an all-zero msr_new.
- R6: While msr_in bit 48 is 0, external and decrementer requests are ignored: no redirect, and srr0, srr1, msr_new and vector keep their values.
- R7: System reset and machine check are never deferred. The same request in consecutive cycles is taken in each, and the later one overwrites srr0 and srr1.
- R8: A synchronous fault that wins arbitration while msr_in bit 48 is 0 sets err_state. It produces no redirect and leaves srr0, srr1, msr_new and vector unchanged.
- R9: While err_state is high every request except system reset is ignored. A taken system reset clears err_state.
- R10: redirect is high for exactly the cycle after each edge at which an exception was taken, so at most one exception is taken per cycle.
- R11: For asynchronous exceptions the two information fields of srr1 are written as zero, whatever sync_info holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_reset | input | 1 | System reset request (nonmaskable) |
| req_mcheck | input | 1 | Machine check request (nonmaskable) |
| req_sync | input | 1 | Synchronous fault from the pipeline |
| req_ext | input | 1 | External interrupt request (maskable) |
| req_dec | input | 1 | Decrementer request (maskable) |
| cur_pc | input | 64 | Address of the faulting instruction |
| next_pc | input | 64 | Address of the next instruction to complete |
| msr_in | input | 64 | Current machine state word |
| sync_info | input | 10 | Exception-specific status for a synchronous fault |
| srr0 | output | 64 | Saved resume address |
| srr1 | output | 64 | Saved status: merged information fields and machine state |
| msr_new | output | 64 | Machine state value for the handler |
| redirect | output | 1 | One-cycle strobe: fetch from vector |
| vector | output | 64 | Handler address |
| err_state | output | 1 | Sticky error after a fault with exceptions disabled |

## Verification
The bench focuses on cycles where arbitration and the saved state interact. In those cycles several requests arrive together, or a nonmaskable request repeats on the next edge and must overwrite the context the previous exception just saved. The bench provokes them with directed stacks of simultaneous requests under both settings of the enable bit. It also drives back-to-back reset and machine check requests with different next_pc values, then runs long runs of biased random requests. Every cycle, a behavioural reference model predicts all outputs from the requirements and the bench compares them, so a wrong winner or a stale saved register shows up in the cycle it occurs.

// File: rtl/exc_pkg.sv
// Package: shared constants, bit positions and the exception kind type
// for the exception entry controller. Assumes 64-bit words numbered
// big-endian (bit 0 = MSB); le() converts to a vector index.
package exc_pkg;

    localparam int XLEN = 64;

    // big-endian positions of the two information fields in srr1
    localparam int SLOT_A_LO = 33;
    localparam int SLOT_A_HI = 36;
    localparam int SLOT_B_LO = 42;
    localparam int SLOT_B_HI = 47;
    localparam int INFO_W    = (SLOT_A_HI - SLOT_A_LO + 1) + (SLOT_B_HI - SLOT_B_LO + 1);

    // big-endian positions of machine state control bits
    localparam int BIT_EE = 48;
    localparam int BIT_PR = 49;
    localparam int BIT_ME = 51;
    localparam int BIT_IR = 58;
    localparam int BIT_DR = 59;

    localparam logic [XLEN-1:0] VEC_RST_D  = XLEN'(64'h100);
    localparam logic [XLEN-1:0] VEC_MCHK_D = XLEN'(64'h200);
    localparam logic [XLEN-1:0] VEC_SYNC_D = XLEN'(64'h700);
    localparam logic [XLEN-1:0] VEC_EXT_D  = XLEN'(64'h500);
    localparam logic [XLEN-1:0] VEC_DEC_D  = XLEN'(64'h900);

    typedef enum logic [2:0] {
        EXC_NONE = 3'd0,
        EXC_RST  = 3'd1,
        EXC_MCHK = 3'd2,
        EXC_SYNC = 3'd3,
        EXC_EXT  = 3'd4,
        EXC_DEC  = 3'd5
    } exc_kind_e;

    // big-endian bit number to vector index
    function automatic int le(input int be);
        return XLEN - 1 - be;
    endfunction

    // one-hot word for a big-endian bit number
    function automatic logic [XLEN-1:0] bitm(input int be);
        return {{(XLEN-1){1'b0}}, 1'b1} << le(be);
    endfunction

    // mask of all srr1 bits owned by the information fields
    function automatic logic [XLEN-1:0] info_mask();
        logic [XLEN-1:0] m;
        m = '0;
        for (int b = SLOT_A_LO; b <= SLOT_A_HI; b++) m = m | bitm(b);
        for (int b = SLOT_B_LO; b <= SLOT_B_HI; b++) m = m | bitm(b);
        return m;
    endfunction

endpackage

// File: rtl/exc_pick.sv
// Arbiter: chooses the single exception to take this cycle.
// Assumes request inputs are levels sampled each cycle; ee is the
// external-enable bit; in_err blocks everything except system reset.
module exc_pick
    import exc_pkg::*;
(
    input  logic      req_reset,
    input  logic      req_mcheck,
    input  logic      req_sync,
    input  logic      req_ext,
    input  logic      req_dec,
    input  logic      ee,
    input  logic      in_err,
    output exc_kind_e kind,
    output logic      fatal
);

    // fixed-priority selection with enable gating and error handling
    always_comb begin
        kind  = EXC_NONE;
        fatal = 1'b0;
        if (req_reset) begin
            kind = EXC_RST;
        end else if (in_err) begin
            kind = EXC_NONE;
        end else if (req_mcheck) begin
            kind = EXC_MCHK;
        end else if (req_sync) begin
            if (ee) kind = EXC_SYNC;
            else    fatal = 1'b1;
        end else if (req_ext && ee) begin
            kind = EXC_EXT;
        end else if (req_dec && ee) begin
            kind = EXC_DEC;
        end
    end

endmodule

// File: rtl/exc_srr1_merge.sv
// Bit-sliced merge for the second save/restore register: two fixed
// big-endian fields take the information bits (or zero when use_info
// is low); every other bit is copied from the machine state word.
module exc_srr1_merge #(
    parameter int W    = 64,
    parameter int IW   = 10,
    parameter int A_LO = 33,
    parameter int A_HI = 36,
    parameter int B_LO = 42,
    parameter int B_HI = 47
) (
    input  logic [W-1:0]  msr,
    input  logic [IW-1:0] info,
    input  logic          use_info,
    output logic [W-1:0]  merged
);

    // one slice per bit, source chosen by its big-endian position
    for (genvar i = 0; i < W; i++) begin : g_bit
        localparam int BE = W - 1 - i;
        if (BE >= A_LO && BE <= A_HI) begin : g_a
            assign merged[i] = use_info & info[IW-1-(BE-A_LO)];
        end else if (BE >= B_LO && BE <= B_HI) begin : g_b
            assign merged[i] = use_info & info[B_HI-BE];
        end else begin : g_m
            assign merged[i] = msr[i];
        end
    end

endmodule

// File: rtl/exc_msr_vec.sv
// Produces the handler machine state value and vector address for a
// given exception kind. Assumes kind is EXC_NONE when nothing is taken.
module exc_msr_vec
    import exc_pkg::*;
#(
    parameter int              W        = XLEN,
    parameter logic [W-1:0]    VEC_RST  = VEC_RST_D,
    parameter logic [W-1:0]    VEC_MCHK = VEC_MCHK_D,
    parameter logic [W-1:0]    VEC_SYNC = VEC_SYNC_D,
    parameter logic [W-1:0]    VEC_EXT  = VEC_EXT_D,
    parameter logic [W-1:0]    VEC_DEC  = VEC_DEC_D
) (
    input  exc_kind_e    kind,
    input  logic [W-1:0] msr_in,
    output logic [W-1:0] msr_new,
    output logic [W-1:0] vec
);

    localparam logic [W-1:0] CLR_BASE = W'(bitm(BIT_EE) | bitm(BIT_PR) | bitm(BIT_IR) | bitm(BIT_DR));
    localparam logic [W-1:0] CLR_MCHK = CLR_BASE | W'(bitm(BIT_ME));

    // new machine state: reset clears all, machine check also drops ME
    always_comb begin
        case (kind)
            EXC_RST:  msr_new = '0;
            EXC_MCHK: msr_new = msr_in & ~CLR_MCHK;
            default:  msr_new = msr_in & ~CLR_BASE;
        endcase
    end

    // vector table lookup
    always_comb begin
        case (kind)
            EXC_RST:  vec = VEC_RST;
            EXC_MCHK: vec = VEC_MCHK;
            EXC_SYNC: vec = VEC_SYNC;
            EXC_EXT:  vec = VEC_EXT;
            EXC_DEC:  vec = VEC_DEC;
            default:  vec = '0;
        endcase
    end

endmodule

// File: rtl/exc_entry_ctrl.sv
// Top: exception entry controller. Arbitrates requests, then registers
// the saved context, new machine state, vector and redirect strobe in
// one stage. Assumes synchronous active-low reset and that the core
// applies msr_new itself after redirect.
module exc_entry_ctrl
    import exc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_reset,
    input  logic              req_mcheck,
    input  logic              req_sync,
    input  logic              req_ext,
    input  logic              req_dec,
    input  logic [XLEN-1:0]   cur_pc,
    input  logic [XLEN-1:0]   next_pc,
    input  logic [XLEN-1:0]   msr_in,
    input  logic [INFO_W-1:0] sync_info,
    output logic [XLEN-1:0]   srr0,
    output logic [XLEN-1:0]   srr1,
    output logic [XLEN-1:0]   msr_new,
    output logic              redirect,
    output logic [XLEN-1:0]   vector,
    output logic              err_state
);

    exc_kind_e         kind;
    logic              fatal;
    logic [XLEN-1:0]   srr1_d;
    logic [XLEN-1:0]   msr_d;
    logic [XLEN-1:0]   vec_d;
    logic              take;

    exc_pick u_pick (
        .req_reset  (req_reset),
        .req_mcheck (req_mcheck),
        .req_sync   (req_sync),
        .req_ext    (req_ext),
        .req_dec    (req_dec),
        .ee         (msr_in[le(BIT_EE)]),
        .in_err     (err_state),
        .kind       (kind),
        .fatal      (fatal)
    );

    exc_srr1_merge #(
        .W    (XLEN),
        .IW   (INFO_W),
        .A_LO (SLOT_A_LO),
        .A_HI (SLOT_A_HI),
        .B_LO (SLOT_B_LO),
        .B_HI (SLOT_B_HI)
    ) u_merge (
        .msr      (msr_in),
        .info     (sync_info),
        .use_info (kind == EXC_SYNC),
        .merged   (srr1_d)
    );

    exc_msr_vec #(
        .W (XLEN)
    ) u_msrvec (
        .kind    (kind),
        .msr_in  (msr_in),
        .msr_new (msr_d),
        .vec     (vec_d)
    );

    assign take = (kind != EXC_NONE);

    // context capture, redirect pulse and sticky error state
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srr0      <= '0;
            srr1      <= '0;
            msr_new   <= '0;
            vector    <= '0;
            redirect  <= 1'b0;
            err_state <= 1'b0;
        end else begin
            redirect <= take;
            if (take) begin
                srr0    <= (kind == EXC_SYNC) ? cur_pc : next_pc;
                srr1    <= srr1_d;
                msr_new <= msr_d;
                vector  <= vec_d;
            end
            if (fatal)                err_state <= 1'b1;
            else if (kind == EXC_RST) err_state <= 1'b0;
        end
    end

endmodule

// File: rtl/exc_entry_chk.sv
// Checker: temporal properties of the exception entry controller,
// attached to every instance of the top by the bind at the end.
module exc_entry_chk
    import exc_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            req_reset,
    input logic            req_mcheck,
    input logic            req_sync,
    input logic [XLEN-1:0] cur_pc,
    input logic [XLEN-1:0] msr_in,
    input logic [XLEN-1:0] srr0,
    input logic [XLEN-1:0] srr1,
    input logic [XLEN-1:0] msr_new,
    input logic            redirect,
    input logic [XLEN-1:0] vector,
    input logic            err_state
);

    localparam logic [XLEN-1:0] IMASK = info_mask();
    localparam int EE = XLEN - 1 - BIT_EE;

    // R2
    reset_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_reset |=> (redirect && vector == VEC_RST_D));

    // R2
    mchk_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_mcheck && !req_reset && !err_state) |=> (redirect && vector == VEC_MCHK_D));

    // R3
    srr0_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync && msr_in[EE] && !req_reset && !req_mcheck && !err_state)
        |=> (srr0 == $past(cur_pc)));

    // R4
    srr1_copy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> (((srr1 ^ $past(msr_in)) & ~IMASK) == '0));

    // R5
    msr_ee_chk: assert property (@(posedge clk) disable iff (!rst_n)
        redirect |-> !msr_new[EE]);

    // R6
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!msr_in[EE] && !req_reset && !req_mcheck && !req_sync) |=> !redirect);

    // R8
    fatal_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_sync && !msr_in[EE] && !req_reset && !req_mcheck && !err_state)
        |=> (err_state && !redirect));

    // R9
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err_state && !req_reset) |=> (err_state && !redirect));

endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (.*);

// File: tb/sim_exc_entry_ctrl.sv
module sim_exc_entry_ctrl;
    import exc_pkg::*;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_reset = 0, req_mcheck = 0, req_sync = 0, req_ext = 0, req_dec = 0;
    logic [63:0]       cur_pc = '0, next_pc = '0, msr_in = '0;
    logic [9:0]        sync_info = '0;
    logic [63:0]       srr0, srr1, msr_new, vector;
    logic              redirect, err_state;

    int checks = 0;
    int errors = 0;

    // reference model state (expected outputs after the next edge)
    logic [63:0] m_srr0 = '0, m_srr1 = '0, m_msr = '0, m_vec = '0;
    logic        m_red = 0, m_err = 0;

    localparam logic [63:0] EEB = 64'h8000;

    always #5 clk = ~clk;

    exc_entry_ctrl u0 (
        .clk(clk), .rst_n(rst_n),
        .req_reset(req_reset), .req_mcheck(req_mcheck), .req_sync(req_sync),
        .req_ext(req_ext), .req_dec(req_dec),
        .cur_pc(cur_pc), .next_pc(next_pc), .msr_in(msr_in), .sync_info(sync_info),
        .srr0(srr0), .srr1(srr1), .msr_new(msr_new), .redirect(redirect),
        .vector(vector), .err_state(err_state)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural prediction from the requirements for the coming edge
    task automatic model_next();
        int k;            // 0 none,1 reset,2 mcheck,3 sync,4 ext,5 dec,9 fatal
        logic [9:0] inf;
        logic ee;
        ee = msr_in[15];
        k = 0;
        if (req_reset)              k = 1;
        else if (m_err)             k = 0;
        else if (req_mcheck)        k = 2;
        else if (req_sync)          k = ee ? 3 : 9;
        else if (req_ext && ee)     k = 4;
        else if (req_dec && ee)     k = 5;
        m_red = (k >= 1 && k <= 5);
        if (k == 9) m_err = 1;
        if (m_red) begin
            m_srr0 = (k == 3) ? cur_pc : next_pc;
            inf = (k == 3) ? sync_info : 10'h0;
            m_srr1 = msr_in;
            m_srr1[30:27] = inf[9:6];
            m_srr1[21:16] = inf[5:0];
            case (k)
                1: m_msr = 64'h0;
                2: m_msr = msr_in & ~64'h0000_0000_0000_D030;
                default: m_msr = msr_in & ~64'h0000_0000_0000_C030;
            endcase
            case (k)
                1: m_vec = 64'h100;
                2: m_vec = 64'h200;
                3: m_vec = 64'h700;
                4: m_vec = 64'h500;
                default: m_vec = 64'h900;
            endcase
            if (k == 1) m_err = 0;
        end
    endtask

    task automatic compare_all();
        chk("R10 redirect", {63'b0, redirect}, {63'b0, m_red});
        chk("R3 srr0", srr0, m_srr0);
        chk("R4 srr1", srr1, m_srr1);
        chk("R5 msr_new", msr_new, m_msr);
        chk("R2 vector", vector, m_vec);
        chk("R8 err_state", {63'b0, err_state}, {63'b0, m_err});
    endtask

    // drive one cycle of inputs at a falling edge, predict, compare at next
    task automatic cyc(input logic r, m, s, e, d,
                       input logic [63:0] pc, npc, msr, input logic [9:0] inf);
        req_reset = r; req_mcheck = m; req_sync = s; req_ext = e; req_dec = d;
        cur_pc = pc; next_pc = npc; msr_in = msr; sync_info = inf;
        model_next();
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle(input logic [63:0] msr);
        cyc(0, 0, 0, 0, 0, 64'h0, 64'h0, msr, 10'h0);
    endtask

    task automatic finish_run();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    // watchdog
    initial begin
        repeat (50000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk("R1 srr0 reset", srr0, 64'h0);
        chk("R1 srr1 reset", srr1, 64'h0);
        chk("R1 msr_new reset", msr_new, 64'h0);
        chk("R1 vector reset", vector, 64'h0);
        chk("R1 redirect reset", {63'b0, redirect}, 64'h0);
        chk("R1 err reset", {63'b0, err_state}, 64'h0);

        // single sources with enable set: R2 vectors, R3, R4, R5, R11
        cyc(0, 0, 1, 0, 0, 64'hAAAA_0000_0000_1000, 64'h1004, EEB, 10'h3FF);
        chk("R2 sync vector", vector, 64'h700);
        chk("R3 sync srr0 = cur_pc", srr0, 64'hAAAA_0000_0000_1000);
        chk("R4 srr1 merge fields", srr1, 64'h0000_0000_783F_8000);
        idle(EEB);
        chk("R10 redirect drops", {63'b0, redirect}, 64'h0);
        cyc(0, 0, 0, 1, 0, 64'h2000, 64'h2004, '1, 10'h3FF);
        chk("R2 ext vector", vector, 64'h500);
        chk("R3 async srr0 = next_pc", srr0, 64'h2004);
        chk("R5 ext msr_new", msr_new, 64'hFFFF_FFFF_FFFF_3FCF);
        chk("R11 async info zero", srr1, {32'hFFFF_FFFF, 32'h87C0_FFFF});
        cyc(0, 1, 0, 0, 0, 64'h0, 64'h3000, '1, 10'h155);
        chk("R5 mcheck msr_new", msr_new, 64'hFFFF_FFFF_FFFF_2FCF);
        cyc(0, 0, 0, 0, 1, 64'h0, 64'h3100, EEB, 10'h0);
        chk("R2 dec vector", vector, 64'h900);
        cyc(1, 0, 0, 0, 0, 64'h0, 64'h3200, '1, 10'h0);
        chk("R5 reset msr_new zero", msr_new, 64'h0);

        // simultaneous requests: R2 priority
        cyc(1, 1, 1, 1, 1, 64'h10, 64'h14, EEB, 10'h1);
        chk("R2 all -> reset", vector, 64'h100);
        cyc(0, 1, 1, 1, 1, 64'h20, 64'h24, EEB, 10'h1);
        chk("R2 mcheck beats sync", vector, 64'h200);
        cyc(0, 0, 1, 1, 1, 64'h30, 64'h34, EEB, 10'h1);
        chk("R2 sync beats ext", vector, 64'h700);
        cyc(0, 0, 0, 1, 1, 64'h40, 64'h44, EEB, 10'h1);
        chk("R2 ext beats dec", vector, 64'h500);

        // R6: maskable ignored with enable clear, state held
        cyc(0, 0, 0, 1, 1, 64'h50, 64'h54, 64'h0, 10'h2);
        chk("R6 no redirect when masked", {63'b0, redirect}, 64'h0);
        chk("R6 srr0 held", srr0, 64'h44);
        chk("R6 vector held", vector, 64'h500);

        // R7: back-to-back nonmaskable overwrite
        cyc(1, 0, 0, 0, 0, 64'h0, 64'h6000, 64'h0, 10'h0);
        cyc(0, 1, 0, 0, 0, 64'h0, 64'h7000, 64'h0, 10'h0);
        chk("R7 second redirect", {63'b0, redirect}, 64'h1);
        chk("R7 srr0 overwritten", srr0, 64'h7000);
        cyc(0, 1, 0, 0, 0, 64'h0, 64'h7100, 64'h0, 10'h0);
        chk("R7 repeat mcheck overwrites", srr0, 64'h7100);

        // R8: fault with exceptions disabled
        cyc(0, 0, 1, 0, 0, 64'h8000, 64'h8004, 64'h0, 10'h3FF);
        chk("R8 err set", {63'b0, err_state}, 64'h1);
        chk("R8 no redirect", {63'b0, redirect}, 64'h0);
        chk("R8 srr0 unchanged", srr0, 64'h7100);

        // R9: only reset escapes error state
        cyc(0, 1, 1, 1, 1, 64'h9000, 64'h9004, EEB, 10'h3);
        chk("R9 mcheck ignored in error", {63'b0, redirect}, 64'h0);
        chk("R9 srr0 held in error", srr0, 64'h7100);
        chk("R9 err held", {63'b0, err_state}, 64'h1);
        cyc(1, 0, 0, 0, 0, 64'h0, 64'hA000, EEB, 10'h0);
        chk("R9 reset taken from error", vector, 64'h100);
        chk("R9 err cleared", {63'b0, err_state}, 64'h0);

        // random traffic compared with the model every cycle
        for (int i = 0; i < 3000; i++) begin
            logic [63:0] msr;
            msr = {$urandom, $urandom};
            if (($urandom % 4) != 0) msr[15] = 1'b1;
            cyc(($urandom % 40) == 0, ($urandom % 12) == 0, ($urandom % 6) == 0,
                ($urandom % 3) == 0, ($urandom % 3) == 0,
                {$urandom, $urandom}, {$urandom, $urandom}, msr, 10'($urandom));
        end

        finish_run();
    end

endmodule